// File: doc/BRIEF.md
# Task-Triggered Serial Control Unit

This block is the register-side controller of a serial port that is driven by tasks and reports through events. Software writes a single word to a task address to start or stop the transmitter and the receiver, and it must first switch the port on by writing a dedicated code to the enable register. Until then, every access except the one to the enable register is ignored.

A one-byte holding register feeds the serializer through a byte/valid pair and is released by a done pulse. Several event flags record transmit completion, received data, line errors and receive shutdown. An error-source register keeps sticky cause bits that software clears by writing ones. The serializer, the receive FIFO and pin routing sit outside this block. The pin-select and baud-rate registers exist only to hold their reset and programmed values.

Top module: `serial_ctl`

## Requirements
- R1: While the port is disabled, `bus_rdata` reads 0 at every address, and any write to an address other than 0x500 changes no state.
- R2: Writing 4 to 0x500 enables the port. Any other non-zero value changes nothing. Writing 0 disables the port, stops the transmitter and the receiver, and sets the receive-timeout event (0x144).
- R3: Writing exactly 1 to 0x008 starts the transmitter, and writing exactly 1 to 0x000 starts the receiver (`rx_on` goes high). Other values have no effect.
- R4: Writing 1 to 0x00C stops only the transmitter. Writing 1 to 0x01C stops both the transmitter and the receiver.
- R5: A receiver stop, by a write of 1 to 0x004, a write of 1 to 0x01C or a disable, lowers `rx_on` and sets the receive-timeout event, which reads 1 at 0x144.
- R6: A write to 0x51C is accepted only while the transmitter is started and no byte is pending. Accepting it raises `tx_valid` and presents bits 7:0 of the write on `tx_data`, which holds steady until done. 0x51C reads the held byte.
- R7: A write to 0x51C while a byte is pending is dropped with no indication. This includes a write in the same cycle as `tx_done`.
- R8: `tx_done` while a byte is pending lowers `tx_valid` and sets the transmit-ready event (0x11C reads 1). `tx_done` with nothing pending has no effect.
- R9: Writing to 0x480 clears the error-source bits written as 1. A `line_break` cycle ORs 3 into 0x480 and sets the error event (0x124). In the same cycle, the break wins over a clear.
- R10: `rx_push` while the receiver is started sets the receive-ready event (0x108). A write of 0 to 0x108 clears it, and a non-zero write leaves it unchanged.
- R11: Writes to 0x11C, 0x124 and 0x144 load bit 0 of the written word. A hardware set in the same cycle takes priority.
- R12: After reset all state is 0 with outputs low. The four pin-select words 0x508, 0x50C, 0x510 and 0x514 read all ones, 0x524 reads 0x04000000, and 0x500 reads 4 while enabled.
- R13: The baud-rate word at 0x524 is writable and reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one word |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| tx_data | output | BYTE_W | Byte handed to the serializer |
| tx_valid | output | 1 | A byte is pending for the serializer |
| tx_done | input | 1 | Serializer finished the pending byte |
| rx_push | input | 1 | Receive side stored a byte |
| line_break | input | 1 | Line break detected |
| rx_on | output | 1 | Receiver is started |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, a 4-bit error-source field, enable code 4 and the standard baud reset word. With these values, every decoded address and the exact enable code can be reached with short write sequences. A behavioural model is compared against the design every cycle. Directed sequences then drive the same-cycle collisions: a done pulse with a transmit write, a break with an error-source clear, and a hardware set with an event write.

// File: rtl/sctl_pkg.sv
`timescale 1ns/1ps
package sctl_pkg;
  localparam int AW = 12;
  localparam int DW = 32;

  localparam logic [AW-1:0] OFS_RX_GO    = 12'h000;
  localparam logic [AW-1:0] OFS_RX_HALT  = 12'h004;
  localparam logic [AW-1:0] OFS_TX_GO    = 12'h008;
  localparam logic [AW-1:0] OFS_TX_HALT  = 12'h00C;
  localparam logic [AW-1:0] OFS_PAUSE    = 12'h01C;
  localparam logic [AW-1:0] OFS_EV_RXRDY = 12'h108;
  localparam logic [AW-1:0] OFS_EV_TXRDY = 12'h11C;
  localparam logic [AW-1:0] OFS_EV_ERR   = 12'h124;
  localparam logic [AW-1:0] OFS_EV_RXTO  = 12'h144;
  localparam logic [AW-1:0] OFS_ERRSRC   = 12'h480;
  localparam logic [AW-1:0] OFS_ENABLE   = 12'h500;
  localparam logic [AW-1:0] OFS_PIN0     = 12'h508;
  localparam logic [AW-1:0] OFS_PIN1     = 12'h50C;
  localparam logic [AW-1:0] OFS_PIN2     = 12'h510;
  localparam logic [AW-1:0] OFS_PIN3     = 12'h514;
  localparam logic [AW-1:0] OFS_TXBYTE   = 12'h51C;
  localparam logic [AW-1:0] OFS_BAUD     = 12'h524;

  // A task fires only on the exact word 1.
  function automatic logic is_trigger(input logic [DW-1:0] v);
    return v == DW'(1);
  endfunction

  // Write-one-to-clear merge with a hardware set that wins.
  function automatic logic [DW-1:0] w1c_merge(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] clr,
                                              input logic [DW-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/sctl_task_ctl.sv
`timescale 1ns/1ps
module sctl_task_ctl
  import sctl_pkg::*;
#(
  parameter logic [DW-1:0] ENABLE_CODE = 32'd4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_enable,
  input  logic          wr_rx_go,
  input  logic          wr_rx_halt,
  input  logic          wr_tx_go,
  input  logic          wr_tx_halt,
  input  logic          wr_pause,
  input  logic [DW-1:0] wdata,
  output logic          en_q,
  output logic          tx_run,
  output logic          rx_run,
  output logic          rxto_set
);
  logic trig, off_cmd, on_cmd, tx_stop;

  assign trig     = is_trigger(wdata);
  assign off_cmd  = wr_enable && (wdata == '0);
  assign on_cmd   = wr_enable && (wdata == ENABLE_CODE);
  assign tx_stop  = off_cmd || (trig && (wr_tx_halt || wr_pause));
  assign rxto_set = off_cmd || (trig && (wr_rx_halt || wr_pause));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      tx_run <= 1'b0;
      rx_run <= 1'b0;
    end else begin
      if (off_cmd)     en_q <= 1'b0;
      else if (on_cmd) en_q <= 1'b1;
      if (tx_stop)                 tx_run <= 1'b0;
      else if (trig && wr_tx_go)   tx_run <= 1'b1;
      if (rxto_set)                rx_run <= 1'b0;
      else if (trig && wr_rx_go)   rx_run <= 1'b1;
    end
  end
endmodule

// File: rtl/sctl_tx_hold.sv
`timescale 1ns/1ps
module sctl_tx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_load,
  input  logic              tx_run,
  input  logic [BYTE_W-1:0] din,
  input  logic              tx_done,
  output logic              pending_q,
  output logic [BYTE_W-1:0] byte_q,
  output logic              txrdy_set
);
  logic accept;

  assign accept    = wr_load && tx_run && !pending_q;
  assign txrdy_set = tx_done && pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      byte_q    <= '0;
    end else if (accept) begin
      pending_q <= 1'b1;
      byte_q    <= din;
    end else if (txrdy_set) begin
      pending_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sctl_events.sv
`timescale 1ns/1ps
module sctl_events
  import sctl_pkg::*;
#(
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_rxrdy,
  input  logic             wr_txrdy,
  input  logic             wr_err,
  input  logic             wr_rxto,
  input  logic             wr_errsrc,
  input  logic [DW-1:0]    wdata,
  input  logic             rx_set,
  input  logic             txrdy_set,
  input  logic             brk_set,
  input  logic             rxto_set,
  output logic             rxrdy_q,
  output logic             txrdy_q,
  output logic             err_q,
  output logic             rxto_q,
  output logic [ERR_W-1:0] errsrc_q
);
  localparam logic [DW-1:0] BRK_BITS = DW'(3);
  logic [DW-1:0] es_next;

  assign es_next = w1c_merge(DW'(errsrc_q),
                             wr_errsrc ? wdata : '0,
                             brk_set ? BRK_BITS : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxrdy_q  <= 1'b0;
      txrdy_q  <= 1'b0;
      err_q    <= 1'b0;
      rxto_q   <= 1'b0;
      errsrc_q <= '0;
    end else begin
      if (rx_set)                          rxrdy_q <= 1'b1;
      else if (wr_rxrdy && wdata == '0)    rxrdy_q <= 1'b0;
      if (txrdy_set)      txrdy_q <= 1'b1;
      else if (wr_txrdy)  txrdy_q <= wdata[0];
      if (brk_set)        err_q <= 1'b1;
      else if (wr_err)    err_q <= wdata[0];
      if (rxto_set)       rxto_q <= 1'b1;
      else if (wr_rxto)   rxto_q <= wdata[0];
      errsrc_q <= es_next[ERR_W-1:0];
    end
  end
endmodule

// File: rtl/serial_ctl.sv
`timescale 1ns/1ps
module serial_ctl
  import sctl_pkg::*;
#(
  parameter int              BYTE_W      = 8,
  parameter int              ERR_W       = 4,
  parameter logic [DW-1:0]   ENABLE_CODE = 32'd4,
  parameter logic [DW-1:0]   BAUD_INIT   = 32'h0400_0000,
  parameter logic [DW-1:0]   PIN_INIT    = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_done,
  input  logic              rx_push,
  input  logic              line_break,
  output logic              rx_on
);
  logic en_q, tx_run, rx_run, rxto_set, acc_wr;
  logic pending_q, txrdy_set;
  logic [BYTE_W-1:0] byte_q;
  logic rxrdy_q, txrdy_q, err_q, rxto_q;
  logic [ERR_W-1:0] errsrc_q;
  logic [DW-1:0] baud_q;

  // Only the enable word gets through while the port is off.
  assign acc_wr = bus_wr && (en_q || bus_addr == OFS_ENABLE);

  function automatic logic hit(input logic [AW-1:0] ofs);
    return acc_wr && (bus_addr == ofs);
  endfunction

  sctl_task_ctl #(.ENABLE_CODE(ENABLE_CODE)) u_task (
    .clk, .rst_n,
    .wr_enable (hit(OFS_ENABLE)),
    .wr_rx_go  (hit(OFS_RX_GO)),
    .wr_rx_halt(hit(OFS_RX_HALT)),
    .wr_tx_go  (hit(OFS_TX_GO)),
    .wr_tx_halt(hit(OFS_TX_HALT)),
    .wr_pause  (hit(OFS_PAUSE)),
    .wdata     (bus_wdata),
    .en_q, .tx_run, .rx_run, .rxto_set
  );

  sctl_tx_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk, .rst_n,
    .wr_load  (hit(OFS_TXBYTE)),
    .tx_run,
    .din      (bus_wdata[BYTE_W-1:0]),
    .tx_done,
    .pending_q, .byte_q, .txrdy_set
  );

  sctl_events #(.ERR_W(ERR_W)) u_evt (
    .clk, .rst_n,
    .wr_rxrdy (hit(OFS_EV_RXRDY)),
    .wr_txrdy (hit(OFS_EV_TXRDY)),
    .wr_err   (hit(OFS_EV_ERR)),
    .wr_rxto  (hit(OFS_EV_RXTO)),
    .wr_errsrc(hit(OFS_ERRSRC)),
    .wdata    (bus_wdata),
    .rx_set   (rx_push && rx_run),
    .txrdy_set,
    .brk_set  (line_break),
    .rxto_set,
    .rxrdy_q, .txrdy_q, .err_q, .rxto_q, .errsrc_q
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              baud_q <= BAUD_INIT;
    else if (hit(OFS_BAUD))  baud_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (en_q) begin
      unique case (bus_addr)
        OFS_EV_RXRDY: bus_rdata = DW'(rxrdy_q);
        OFS_EV_TXRDY: bus_rdata = DW'(txrdy_q);
        OFS_EV_ERR:   bus_rdata = DW'(err_q);
        OFS_EV_RXTO:  bus_rdata = DW'(rxto_q);
        OFS_ERRSRC:   bus_rdata = DW'(errsrc_q);
        OFS_ENABLE:   bus_rdata = ENABLE_CODE;
        OFS_PIN0, OFS_PIN1, OFS_PIN2, OFS_PIN3: bus_rdata = PIN_INIT;
        OFS_TXBYTE:   bus_rdata = DW'(byte_q);
        OFS_BAUD:     bus_rdata = baud_q;
        default:      bus_rdata = '0;
      endcase
    end
  end

  assign tx_data  = byte_q;
  assign tx_valid = pending_q;
  assign rx_on    = rx_run;
endmodule

// File: rtl/serial_ctl_chk.sv
`timescale 1ns/1ps
module serial_ctl_chk #(
  parameter int BYTE_W = 8,
  parameter int ERR_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_q,
  input logic              bus_wr,
  input logic [11:0]       bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_valid,
  input logic              tx_done,
  input logic              rx_on,
  input logic              rxto_set,
  input logic              line_break,
  input logic              err_q,
  input logic [ERR_W-1:0]  errsrc_q
);
  assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> bus_rdata == 32'd0);

  assert_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h500 && bus_wdata == 32'd0) |=> (!en_q && !rx_on));

  assert_rxstop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rxto_set |=> !rx_on);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_done) |=> (tx_valid && $stable(tx_data)));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_done) |=> !tx_valid);

  assert_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_break |=> (err_q && errsrc_q[1:0] == 2'b11));
endmodule

bind serial_ctl serial_ctl_chk #(.BYTE_W(BYTE_W), .ERR_W(ERR_W)) u_chk (.*);

// File: tb/tb_serial_ctl.sv
`timescale 1ns/1ps
module tb_serial_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0] tx_data;
  logic tx_valid, rx_on;
  logic tx_done = 1'b0, rx_push = 1'b0, line_break = 1'b0;

  int checks = 0, errors = 0;
  bit model_live = 1'b0;

  always #4 clk = ~clk;

  serial_ctl dut (.*);

  // ---------------- behavioural reference ----------------
  bit m_en, m_tr, m_rr, m_pend, m_rxrdy, m_txrdy, m_err, m_rxto;
  logic [7:0] m_byte;
  logic [3:0] m_es;
  logic [31:0] m_baud;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_en, m_tr, m_rr, m_pend, m_rxrdy, m_txrdy, m_err, m_rxto} = '0;
      m_byte = 0; m_es = 0; m_baud = 32'h0400_0000;
    end else begin
      bit old_pend, old_rr, live;
      old_pend = m_pend; old_rr = m_rr;
      live = bus_wr && (m_en || bus_addr == 12'h500);
      if (live) begin
        case (bus_addr)
          12'h500: if (bus_wdata == 0) begin m_en = 0; m_tr = 0; m_rr = 0; m_rxto = 1; end
                   else if (bus_wdata == 4) m_en = 1;
          12'h000: if (bus_wdata == 1) m_rr = 1;
          12'h004: if (bus_wdata == 1) begin m_rr = 0; m_rxto = 1; end
          12'h008: if (bus_wdata == 1) m_tr = 1;
          12'h00C: if (bus_wdata == 1) m_tr = 0;
          12'h01C: if (bus_wdata == 1) begin m_tr = 0; m_rr = 0; m_rxto = 1; end
          12'h51C: if (m_tr && !old_pend) begin m_pend = 1; m_byte = bus_wdata[7:0]; end
          12'h108: if (bus_wdata == 0) m_rxrdy = 0;
          12'h11C: m_txrdy = bus_wdata[0];
          12'h124: m_err = bus_wdata[0];
          12'h144: m_rxto = bus_wdata[0];
          12'h480: m_es = m_es & ~bus_wdata[3:0];
          12'h524: m_baud = bus_wdata;
          default: ;
        endcase
      end
      if (tx_done && old_pend) begin m_pend = 0; m_txrdy = 1; end
      if (rx_push && old_rr) m_rxrdy = 1;
      if (line_break) begin m_es = m_es | 4'd3; m_err = 1; end
    end
  end

  function automatic logic [31:0] mread(input logic [11:0] a);
    if (!m_en) return 0;
    case (a)
      12'h108: return {31'd0, m_rxrdy};
      12'h11C: return {31'd0, m_txrdy};
      12'h124: return {31'd0, m_err};
      12'h144: return {31'd0, m_rxto};
      12'h480: return {28'd0, m_es};
      12'h500: return 32'd4;
      12'h508, 12'h50C, 12'h510, 12'h514: return 32'hFFFF_FFFF;
      12'h51C: return {24'd0, m_byte};
      12'h524: return m_baud;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && model_live) begin
      check("R6 tx_valid vs model", {31'd0, tx_valid}, {31'd0, m_pend});
      check("R6 tx_data vs model", {24'd0, tx_data}, {24'd0, m_byte});
      check("R3 rx_on vs model", {31'd0, rx_on}, {31'd0, m_rr});
      check("R1 rdata vs model", bus_rdata, mread(bus_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input bit w, input logic [11:0] a, input logic [31:0] d,
                     input bit dn, input bit brk, input bit push);
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d;
    tx_done = dn; line_break = brk; rx_push = push;
    @(negedge clk);
    bus_wr = 0; tx_done = 0; line_break = 0; rx_push = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_live = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 tx_valid after reset", {31'd0, tx_valid}, 0);
    check("R12 rx_on after reset", {31'd0, rx_on}, 0);
    // R1 disabled gating
    rd("R1 disabled read of baud", 12'h524, 0);
    wr(12'h008, 1); wr(12'h000, 1);
    check("R1 start ignored while off", {31'd0, rx_on}, 0);
    // R2 wrong code
    wr(12'h500, 5);
    rd("R2 code 5 keeps port off", 12'h524, 0);
    wr(12'h500, 4);
    rd("R12 baud reset word", 12'h524, 32'h0400_0000);
    rd("R12 pin select 0", 12'h508, 32'hFFFF_FFFF);
    rd("R12 pin select 3", 12'h514, 32'hFFFF_FFFF);
    rd("R12 enable readback", 12'h500, 4);
    rd("R12 errsrc clear", 12'h480, 0);
    wr(12'h51C, 8'h77);
    check("R1 earlier tx start was ignored", {31'd0, tx_valid}, 0);
    // R3 non-trigger value
    wr(12'h008, 2); wr(12'h51C, 8'h66);
    check("R3 value 2 does not start tx", {31'd0, tx_valid}, 0);
    wr(12'h008, 1); wr(12'h51C, 8'hA5);
    check("R6 accepted byte valid", {31'd0, tx_valid}, 1);
    check("R6 accepted byte value", {24'd0, tx_data}, 8'hA5);
    rd("R6 held byte readback", 12'h51C, 8'hA5);
    wr(12'h51C, 8'h3C);
    check("R7 pending write dropped", {24'd0, tx_data}, 8'hA5);
    cyc(0, 12'h11C, 0, 1, 0, 0);
    check("R8 done releases", {31'd0, tx_valid}, 0);
    rd("R8 txrdy set", 12'h11C, 1);
    wr(12'h11C, 0);
    rd("R11 txrdy loads 0", 12'h11C, 0);
    cyc(0, 12'h11C, 0, 1, 0, 0);
    rd("R8 idle done no effect", 12'h11C, 0);
    // R11 hardware set wins over event write
    wr(12'h51C, 8'h10);
    cyc(1, 12'h11C, 0, 1, 0, 0);
    rd("R11 done beats write 0", 12'h11C, 1);
    // R7 same-cycle done and write
    wr(12'h51C, 8'h22);
    cyc(1, 12'h51C, 8'h33, 1, 0, 0);
    check("R7 write in done cycle dropped", {31'd0, tx_valid}, 0);
    rd("R7 byte unchanged", 12'h51C, 8'h22);
    // R10 receive ready
    wr(12'h000, 1);
    check("R3 rx started", {31'd0, rx_on}, 1);
    cyc(0, 12'h108, 0, 0, 0, 1);
    rd("R10 rx_push sets rxrdy", 12'h108, 1);
    wr(12'h108, 5);
    rd("R10 nonzero write keeps rxrdy", 12'h108, 1);
    wr(12'h108, 0);
    rd("R10 zero write clears rxrdy", 12'h108, 0);
    // R4 stop tx only
    wr(12'h00C, 1); wr(12'h51C, 8'h44);
    check("R4 tx stopped", {31'd0, tx_valid}, 0);
    check("R4 rx still on", {31'd0, rx_on}, 1);
    rd("R4 no rx timeout from tx stop", 12'h144, 0);
    // R5 stop rx
    wr(12'h004, 1);
    check("R5 rx off", {31'd0, rx_on}, 0);
    rd("R5 rx timeout set", 12'h144, 1);
    wr(12'h144, 0);
    rd("R11 rxto loads 0", 12'h144, 0);
    cyc(0, 12'h108, 0, 0, 0, 1);
    rd("R10 push ignored when rx off", 12'h108, 0);
    // R4 suspend
    wr(12'h000, 1); wr(12'h008, 1); wr(12'h01C, 1);
    check("R4 suspend stops rx", {31'd0, rx_on}, 0);
    wr(12'h51C, 8'h55);
    check("R4 suspend stops tx", {31'd0, tx_valid}, 0);
    rd("R5 suspend sets rxto", 12'h144, 1);
    // R9 error source
    cyc(0, 12'h480, 0, 0, 1, 0);
    rd("R9 break ORs 3", 12'h480, 3);
    rd("R9 error event", 12'h124, 1);
    wr(12'h480, 1);
    rd("R9 w1c clears bit0", 12'h480, 2);
    cyc(1, 12'h480, 3, 0, 1, 0);
    rd("R9 break beats clear", 12'h480, 3);
    wr(12'h124, 0);
    rd("R11 err loads 0", 12'h124, 0);
    // R13 baud
    wr(12'h524, 32'h0000_1234);
    rd("R13 baud readback", 12'h524, 32'h0000_1234);
    // R2 disable and re-enable
    wr(12'h144, 0); wr(12'h000, 1); wr(12'h008, 1);
    wr(12'h500, 0);
    check("R2 disable stops rx", {31'd0, rx_on}, 0);
    rd("R1 disabled read of rxto", 12'h144, 0);
    wr(12'h524, 32'hDEAD);
    wr(12'h500, 4);
    rd("R1 baud untouched while off", 12'h524, 32'h0000_1234);
    rd("R2 disable set rxto", 12'h144, 1);
    wr(12'h51C, 8'h99);
    check("R2 disable stopped tx", {31'd0, tx_valid}, 0);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule